// File: doc/BRIEF.md
# TLB Replacement Random Index Generator

This block picks a victim entry for TLB replacement. Each accepted request advances a 32-bit multiply-add congruential state. The upper half of the new state is then reduced into the window of replaceable entries. That window runs from the wired count up to the last entry, so wired (locked) entries are never chosen. The reduction uses a restoring shift-subtract divider. The divider has a fixed latency, and while it runs the block reports busy.

The consumer pulses a request with the current wired and total entry counts. It then waits for the one-cycle valid strobe and takes the index. If the wired count covers the whole TLB, there is nothing to divide: the block answers on the next cycle with the highest entry index.

Top module: `tlb_rand_index`

## Requirements
- R1: After reset the state word is 0, `victim_vld` is 0 and `busy` is 0, so the first accepted request produces state 1, whose upper 16 bits are 0, and returns index equal to the wired count.
- R2: Each accepted request (`req` high while `busy` low at a rising edge) replaces the state with state × 314159 + 1, modulo 2^32; with no accepted request the state holds.
- R3: When wired < total, the returned index equals (state[31:16] mod (total − wired)) + wired, computed on the updated state, so it always lies in [wired, total−1].
- R4: On the divider path `busy` is high from the edge after the accepting edge through the 16th edge after it. `victim_vld` rises for exactly one cycle at that 16th edge, in the same edge where `busy` falls.
- R5: A request seen while `busy` is high is ignored: the state does not advance and no extra result is produced.
- R6: When wired ≥ total, `victim_vld` is high for one cycle after the accepting edge with `victim_idx` = total − 1. `busy` stays low and the state still advances.
- R7: The wired and total counts are sampled only at the accepting edge; changing them while `busy` is high does not affect the pending result.
- R8: The full range of total counts 1 to 64 is handled on a 6-bit index, including a window of 64 entries (wired 0, total 64) and a window of one entry (result equals wired).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request for a new victim index |
| wired_cnt | input | 7 | Number of wired entries at the bottom of the TLB |
| entry_cnt | input | 7 | Total number of TLB entries (1 to 64) |
| victim_idx | output | 6 | Chosen entry index, meaningful while `victim_vld` is high |
| victim_vld | output | 1 | One-cycle strobe marking a new index |
| busy | output | 1 | Divider running; requests are ignored |

## Verification
The hardest situation to reach from the ports is a request that lands mid-division. It must leave the state untouched, and the result must still use counts that have since changed. From the ports alone it looks like an ordinary slow result. The stimulus fires a second request and moves both counts partway through a division. It then checks that the pending result uses the old counts. A follow-up request must give the value the reference sequence predicts after exactly one step, which would differ if the stray request had advanced the state.

// File: rtl/tlb_rand_index.sv
module tlb_rand_index #(
  parameter int SEED_W = 32,
  parameter int MULT   = 314159,
  parameter int INC    = 1,
  parameter int TAKE_W = 16,
  parameter int ENT_W  = 7,
  parameter int IDX_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [ENT_W-1:0] wired_cnt,
  input  logic [ENT_W-1:0] entry_cnt,
  output logic [IDX_W-1:0] victim_idx,
  output logic             victim_vld,
  output logic             busy
);
  localparam int STEPS = TAKE_W;
  localparam int CNT_W = $clog2(STEPS + 1);
  localparam logic [SEED_W-1:0] MULT_V = SEED_W'(MULT);
  localparam logic [SEED_W-1:0] INC_V  = SEED_W'(INC);

  logic [SEED_W-1:0] seed;
  logic [SEED_W-1:0] seed_nx;
  logic [TAKE_W-1:0] dvd;
  logic [ENT_W-1:0]  rem, win, base;
  logic [CNT_W-1:0]  cnt;

  logic              accept;
  logic              no_window;
  logic [ENT_W-1:0]  trial, step_rem, sum, last;

  assign seed_nx   = seed * MULT_V + INC_V;
  assign accept    = req & ~busy;
  assign no_window = wired_cnt >= entry_cnt;
  assign trial     = {rem[ENT_W-2:0], dvd[TAKE_W-1]};
  assign step_rem  = (trial >= win) ? trial - win : trial;
  assign sum       = step_rem + base;
  assign last      = entry_cnt - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seed       <= '0;
      dvd        <= '0;
      rem        <= '0;
      win        <= '0;
      base       <= '0;
      cnt        <= '0;
      busy       <= 1'b0;
      victim_vld <= 1'b0;
      victim_idx <= '0;
    end else begin
      victim_vld <= 1'b0;
      if (accept) begin
        seed <= seed_nx;
        base <= wired_cnt;
        win  <= entry_cnt - wired_cnt;
        if (no_window) begin
          victim_vld <= 1'b1;
          victim_idx <= last[IDX_W-1:0];
        end else begin
          busy <= 1'b1;
          dvd  <= seed_nx[SEED_W-1 -: TAKE_W];
          rem  <= '0;
          cnt  <= CNT_W'(STEPS);
        end
      end else if (busy) begin
        dvd <= dvd << 1;
        rem <= step_rem;
        cnt <= cnt - 1'b1;
        if (cnt == CNT_W'(1)) begin
          busy       <= 1'b0;
          victim_vld <= 1'b1;
          victim_idx <= sum[IDX_W-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/tlb_rand_index_chk.sv
module tlb_rand_index_chk #(
  parameter int SEED_W = 32,
  parameter int ENT_W  = 7,
  parameter int IDX_W  = 6,
  parameter int STEPS  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req,
  input logic              busy,
  input logic              victim_vld,
  input logic [IDX_W-1:0]  victim_idx,
  input logic [SEED_W-1:0] seed,
  input logic [ENT_W-1:0]  base,
  input logic [ENT_W-1:0]  win
);
  logic [7:0] run;
  logic [ENT_W-1:0] off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= '0;
    else if (busy) run <= run + 1'b1;
    else run <= '0;
  end

  assign off = {1'b0, victim_idx} - base;

  assert_state_moves_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req && !busy |=> seed != $past(seed));

  assert_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ({1'b0, victim_idx} >= base) && (off < win));

  assert_busy_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run == 8'(STEPS)) && victim_vld);

  assert_no_vld_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !victim_vld);

  assert_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy && req |=> $stable(seed));
endmodule

bind tlb_rand_index tlb_rand_index_chk #(
  .SEED_W(SEED_W), .ENT_W(ENT_W), .IDX_W(IDX_W), .STEPS(TAKE_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .req(req), .busy(busy),
  .victim_vld(victim_vld), .victim_idx(victim_idx),
  .seed(seed), .base(base), .win(win)
);

// File: tb/tlb_rand_index_tb_top.sv
`timescale 1ns/1ps
module tlb_rand_index_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0;
  logic [6:0] wired_cnt = '0;
  logic [6:0] entry_cnt = 7'd1;
  logic [5:0] victim_idx;
  logic       victim_vld;
  logic       busy;

  int checks = 0;
  int fails  = 0;
  logic [31:0] mseed = '0;

  always #2.5 clk = ~clk;

  tlb_rand_index dut_i (
    .clk(clk), .rst_n(rst_n), .req(req),
    .wired_cnt(wired_cnt), .entry_cnt(entry_cnt),
    .victim_idx(victim_idx), .victim_vld(victim_vld), .busy(busy)
  );

  localparam int NV = 8;
  localparam logic [13:0] VEC [NV] = '{
    {7'd0,  7'd64}, {7'd8,  7'd48}, {7'd3,  7'd4},  {7'd0,  7'd1},
    {7'd63, 7'd64}, {7'd10, 7'd17}, {7'd1,  7'd32}, {7'd20, 7'd64}
  };

  task automatic chk(input logic ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic int expect_idx(input int w, input int t);
    return int'(mseed[31:16]) % (t - w) + w;
  endfunction

  task automatic issue(input int w, input int t);
    @(negedge clk);
    wired_cnt = 7'(w);
    entry_cnt = 7'(t);
    req = 1'b1;
    @(posedge clk);
    #1 req = 1'b0;
    mseed = mseed * 32'd314159 + 32'd1;
  endtask

  task automatic run_one(input int w, input int t, input string rq);
    issue(w, t);
    if (w >= t) begin
      @(negedge clk);
      chk(victim_vld && !busy, "R6 strobe", int'(victim_vld), 1);
      chk(victim_idx == 6'(t - 1), "R6 index", int'(victim_idx), t - 1);
    end else begin
      repeat (15) @(posedge clk);
      @(negedge clk);
      chk(busy && !victim_vld, "R4 busy before result", int'(victim_vld), 0);
      @(posedge clk);
      @(negedge clk);
      chk(victim_vld && !busy, "R4 result strobe", int'(victim_vld), 1);
      chk(int'(victim_idx) == expect_idx(w, t), rq, int'(victim_idx), expect_idx(w, t));
      @(negedge clk);
      chk(!victim_vld, "R4 single pulse", int'(victim_vld), 0);
    end
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!victim_vld && !busy, "R1 reset outputs", int'(busy), 0);
    rst_n = 1'b1;

    run_one(5, 30, "R1 first index equals wired");

    for (int i = 0; i < NV; i++) begin
      int w, t;
      w = int'(VEC[i][13:7]);
      t = int'(VEC[i][6:0]);
      run_one(w, t, "R3 R8 table index");
    end

    // R6: wired equal to and above total, back to back
    run_one(16, 16, "R6 equal");
    run_one(40, 12, "R6 above");

    // R8: window of one entry
    run_one(31, 32, "R8 single-entry window");

    // R5 / R7: stray request and moved counts during busy
    issue(4, 40);
    repeat (3) @(posedge clk);
    @(negedge clk);
    req = 1'b1;
    wired_cnt = 7'd30;
    entry_cnt = 7'd33;
    @(negedge clk);
    req = 1'b0;
    repeat (12) @(posedge clk);
    @(negedge clk);
    chk(victim_vld, "R7 result after stray request", int'(victim_vld), 1);
    chk(int'(victim_idx) == expect_idx(4, 40), "R7 counts latched",
        int'(victim_idx), expect_idx(4, 40));
    run_one(2, 50, "R5 state advanced once");

    // R2: several more steps of the sequence
    for (int k = 0; k < 4; k++) run_one(0, 64, "R2 sequence step");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule